// File: doc/BRIEF.md
# Pipelined Signed Adder Tree

This block reduces a parameterized number of signed operands, all presented on the same clock cycle, to their exact signed total. Operands pair off with their neighbours at each stage. Each pair is widened by one bit, added and registered, so the word grows by exactly one bit per stage and can never overflow.

When a stage holds an odd number of operands, the leftover one is not added. It is sign-extended by one bit and registered, so it reaches the next stage in step with the pair sums. Because every path through the tree then has the same register depth, input counts that are not a power of two are summed correctly. A fresh operand vector may be applied on every cycle, and the tree never stalls. With a single operand the structure collapses to a wire.

Top module: `signed_adder_tree`

## Requirements
- R1: Operand i occupies bits [i*IN_W +: IN_W] of `in_vec` as a two's complement value. `sum_out`, read as two's complement, equals the exact sum of all NUM_IN operands.
- R2: For NUM_IN > 1 the latency is ceil(log2 NUM_IN) clock cycles. A new operand vector is accepted every cycle, with no stall or gap.
- R3: `sum_out` is IN_W + ceil(log2 NUM_IN) bits wide. The result is exact with no overflow, including when every operand is the most negative value (0x80 for 8 bits) or the most positive value (0x7F for 8 bits).
- R4: At every stage, operands 2j and 2j+1 are added together. An unpaired last operand is delayed by one register stage with sign extension, so odd counts at any stage (for example NUM_IN = 3, 5, 9) give correct, aligned totals.
- R5: With NUM_IN = 1, `sum_out` equals the single operand combinationally, with zero latency and no growth in width.
- R6: A clock edge with `rst` high clears every pipeline register, so `sum_out` reads zero after that edge for any NUM_IN > 1, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages register on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all stages |
| in_vec | input | NUM_IN*IN_W | Packed signed operands, operand 0 in the lowest bits |
| sum_out | output | IN_W+ceil(log2 NUM_IN) | Signed total of the operands |

## Verification
The bench builds six copies with 8-bit operands and operand counts of 1, 2, 3, 5, 8 and 9. These give latencies of 0 to 4 cycles. They cover the wire-only variant, pure power-of-two trees, and trees where the leftover register appears at the first stage, at a later stage, or at several stages. Streams of all-minimum and all-maximum operands drive each width to its extreme totals. Reset pulses in the middle of a stream show the pipelines clearing and then refilling at their own latency.

// File: rtl/atree_pkg.sv
package atree_pkg;

   // number of elements present at stage k for n operands: ceil(n / 2^k)
   function automatic int stage_count(input int n, input int k);
      return (n + (1 << k) - 1) >> k;
   endfunction

endpackage

// File: rtl/atree_pair_add.sv
module atree_pair_add #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W:0]   sum
);
   if (W < 2) begin : g_bad_w
      $error("atree_pair_add: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) sum <= '0;
      else     sum <= {opa[W-1], opa} + {opb[W-1], opb};
   end

   // two non-negative operands never yield a negative registered sum
   assert_nonneg_R3: assert property (@(posedge clk) disable iff (rst)
      (!opa[W-1] && !opb[W-1]) |=> !sum[W]);
   // two negative operands always yield a negative registered sum
   assert_neg_R3: assert property (@(posedge clk) disable iff (rst)
      (opa[W-1] && opb[W-1]) |=> sum[W]);
   assert_pair_clear_R6: assert property (@(posedge clk)
      rst |=> (sum == '0));
endmodule

// File: rtl/atree_pad_reg.sv
module atree_pad_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W:0]   q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= {d[W-1], d};
   end

   // leftover operand reaches the next stage with its value unchanged (R4)
   assert_pad_keep_R4: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ($signed(q) == $signed({$past(d[W-1]), $past(d)})) || $past(rst));
   assert_pad_clear_R6: assert property (@(posedge clk)
      rst |=> (q == '0));
endmodule

// File: rtl/atree_level.sv
module atree_level #(
   parameter int IN_CNT = 2,
   parameter int W      = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [IN_CNT*W-1:0]           d_in,
   output logic [((IN_CNT+1)/2)*(W+1)-1:0] d_out
);
   localparam int PAIRS = IN_CNT / 2;
   localparam bit ODD   = (IN_CNT % 2) != 0;

   if (IN_CNT < 2) begin : g_bad_cnt
      $error("atree_level: a stage needs at least two elements");
   end

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      atree_pair_add #(.W(W)) u_add (
         .clk (clk),
         .rst (rst),
         .opa (d_in[(2*p)*W +: W]),
         .opb (d_in[(2*p+1)*W +: W]),
         .sum (d_out[p*(W+1) +: W+1])
      );
   end

   if (ODD) begin : g_pad
      atree_pad_reg #(.W(W)) u_pad (
         .clk (clk),
         .rst (rst),
         .d   (d_in[(IN_CNT-1)*W +: W]),
         .q   (d_out[PAIRS*(W+1) +: W+1])
      );
   end
endmodule

// File: rtl/signed_adder_tree.sv
module signed_adder_tree
   import atree_pkg::*;
#(
   parameter int NUM_IN = 9,
   parameter int IN_W   = 8,
   localparam int LVLS  = $clog2(NUM_IN),
   localparam int OUT_W = IN_W + LVLS
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_IN*IN_W-1:0] in_vec,
   output logic [OUT_W-1:0]       sum_out
);
   if (NUM_IN < 1) begin : g_bad_n
      $error("signed_adder_tree: NUM_IN must be at least 1");
   end
   if (IN_W < 2) begin : g_bad_w
      $error("signed_adder_tree: IN_W must be at least 2");
   end

   localparam longint MIN_TOT = -(longint'(NUM_IN) * (longint'(1) <<< (IN_W-1)));
   localparam longint MAX_TOT = longint'(NUM_IN) * ((longint'(1) <<< (IN_W-1)) - 1);

   function automatic longint operand_total(input logic [NUM_IN*IN_W-1:0] v);
      longint acc = 0;
      for (int i = 0; i < NUM_IN; i++) acc += longint'($signed(v[i*IN_W +: IN_W]));
      return acc;
   endfunction

   if (LVLS == 0) begin : g_wire
      assign sum_out = in_vec;
      always_comb assert_wire_R5: assert (sum_out == in_vec);
   end else begin : g_tree
      for (genvar k = 0; k <= LVLS; k++) begin : g_lvl
         logic [stage_count(NUM_IN, k)*(IN_W+k)-1:0] bus;
         if (k == 0) begin : g_src
            assign bus = in_vec;
         end else begin : g_stage
            atree_level #(
               .IN_CNT (stage_count(NUM_IN, k-1)),
               .W      (IN_W + k - 1)
            ) u_level (
               .clk   (clk),
               .rst   (rst),
               .d_in  (g_lvl[k-1].bus),
               .d_out (bus)
            );
         end
      end
      assign sum_out = g_lvl[LVLS].bus;

      // checker state: how many consecutive edges captured the same vector
      localparam int CW = $clog2(LVLS + 2);
      logic [NUM_IN*IN_W-1:0] prev_in;
      logic [CW-1:0]          hold_cnt;
      always_ff @(posedge clk) begin
         prev_in <= in_vec;
         if (rst)                       hold_cnt <= '0;
         else if (in_vec != prev_in)    hold_cnt <= CW'(1);
         else if (hold_cnt < CW'(LVLS)) hold_cnt <= hold_cnt + CW'(1);
      end

      assert_steady_R2: assert property (@(posedge clk) disable iff (rst)
         (hold_cnt >= CW'(LVLS)) |-> (longint'($signed(sum_out)) == operand_total(prev_in)));
      assert_range_R3: assert property (@(posedge clk) disable iff (rst)
         (longint'($signed(sum_out)) >= MIN_TOT) && (longint'($signed(sum_out)) <= MAX_TOT));
   end
endmodule

// File: tb/tb_signed_adder_tree.sv
module tb_signed_adder_tree;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst  = 1'b1;
   logic [71:0] stim = '0;
   logic [7:0]  o1;
   logic [8:0]  o2;
   logic [9:0]  o3;
   logic [10:0] o5;
   logic [10:0] o8;
   logic [11:0] o9;

   signed_adder_tree #(.NUM_IN(9), .IN_W(8)) dut    (.clk(clk), .rst(rst), .in_vec(stim[71:0]), .sum_out(o9));
   signed_adder_tree #(.NUM_IN(1), .IN_W(8)) dut_n1 (.clk(clk), .rst(rst), .in_vec(stim[7:0]),  .sum_out(o1));
   signed_adder_tree #(.NUM_IN(2), .IN_W(8)) dut_n2 (.clk(clk), .rst(rst), .in_vec(stim[15:0]), .sum_out(o2));
   signed_adder_tree #(.NUM_IN(3), .IN_W(8)) dut_n3 (.clk(clk), .rst(rst), .in_vec(stim[23:0]), .sum_out(o3));
   signed_adder_tree #(.NUM_IN(5), .IN_W(8)) dut_n5 (.clk(clk), .rst(rst), .in_vec(stim[39:0]), .sum_out(o5));
   signed_adder_tree #(.NUM_IN(8), .IN_W(8)) dut_n8 (.clk(clk), .rst(rst), .in_vec(stim[63:0]), .sum_out(o8));

   int errs = 0, checks = 0, cyc = 0, run = 0;
   bit done = 1'b0;
   string ph = "R1";
   logic [71:0] hist [16];
   bit          rhist[16];

   function automatic longint esum(input logic [71:0] v, input int n);
      longint acc = 0;
      for (int i = 0; i < n; i++) acc += longint'($signed(v[i*8 +: 8]));
      return acc;
   endfunction

   function automatic logic [71:0] rnd();
      return {$urandom, $urandom, $urandom} >> 24;
   endfunction

   task automatic chk(input string tag, input int n, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s N=%0d cycle=%0d actual=%0d expected=%0d", ph, tag, n, cyc, act, exp);
      end
   endtask

   // reference: output after an edge = total captured (lat-1) edges earlier,
   // valid once lat reset-free edges have passed; zero after a reset edge
   task automatic lane(input int n, input int lat, input longint act);
      if (lat == 0)
         chk("R5", n, act, esum(stim, n));
      else if (rhist[cyc % 16])
         chk("R6", n, act, 0);
      else if (run >= lat)
         chk((n % 2) ? "R4" : "R2", n, act, esum(hist[(cyc - lat + 1) % 16], n));
   endtask

   task automatic step(input logic r, input logic [71:0] s);
      @(negedge clk);
      rst  = r;
      stim = s;
      @(posedge clk);
      hist[cyc % 16]  = stim;
      rhist[cyc % 16] = rst;
      run = rst ? 0 : run + 1;
      #5;
      lane(1, 0, longint'($signed(o1)));
      lane(2, 1, longint'($signed(o2)));
      lane(3, 2, longint'($signed(o3)));
      lane(5, 3, longint'($signed(o5)));
      lane(8, 3, longint'($signed(o8)));
      lane(9, 4, longint'($signed(o9)));
      cyc++;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      // R3: output width grows by ceil(log2 N)
      chk("R3", 1, $bits(o1), 8);
      chk("R3", 3, $bits(o3), 10);
      chk("R3", 5, $bits(o5), 11);
      chk("R3", 9, $bits(o9), 12);
      // R6: reset with nonzero operands
      for (int i = 0; i < 3; i++) step(1'b1, rnd());
      ph = "R1";
      for (int i = 0; i < 40; i++) step(1'b0, rnd());
      ph = "R3";
      for (int i = 0; i < 6; i++) step(1'b0, {9{8'h80}});
      for (int i = 0; i < 6; i++) step(1'b0, {9{8'h7f}});
      for (int i = 0; i < 8; i++) step(1'b0, (i % 2) ? {9{8'h80}} : {9{8'h7f}});
      for (int i = 0; i < 4; i++) step(1'b0, {5{16'h7f80}} >> 8);
      ph = "R1";
      for (int i = 0; i < 9; i++) step(1'b0, 72'hff << (8*i));
      for (int i = 0; i < 4; i++) step(1'b0, '0);
      // mid-stream reset, then refill
      for (int i = 0; i < 2; i++) step(1'b1, rnd());
      for (int i = 0; i < 20; i++) step(1'b0, rnd());
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL R2 watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end
endmodule